// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a synchronous host and one port of an asynchronous static RAM. The host raises a write request with an address, a data word and a flag that says whether the RAM's output enable is to be held low during the write. The block accepts the request when it is idle and captures all three values. It then plays out the RAM control waveform on registered outputs: chip enable, the write strobe, output enable, the address, and a data word with its bus drive enable. When the cycle is complete it returns a one-cycle acknowledge.

Every analog timing limit is a parameter in nanoseconds, set next to the clock period. Each one becomes a whole number of clock cycles by rounding up. A nonzero interval always takes at least one cycle, and a zero interval takes none. The strobe is made longer when output enable is low, so that the RAM's own drivers can turn off before the data has to be valid. A busy input from an external port arbiter holds the strobe back. The strobe may start only after busy has been low for a set settling interval.

Top module: `sram_wr_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1 and `sram_drive` and `ack` are 0. A request presented during reset is not accepted.
- R2: A request is accepted only on a clock where the block is idle, `req` is 1 and `ack` is 0. Address, data and output-enable mode are captured at that edge. Later changes on `req_addr`, `req_data` and `req_oe_low` do not alter the cycle in progress.
- R3: `sram_ce_n` falls on the acceptance edge. `sram_we_n` falls S cycles later, where S = max(ceil(tAS/Tclk), 1), which is 1 with the defaults. `sram_we_n` is low only while `sram_ce_n` is low. `sram_addr` changes only on an edge where both strobes were high.
- R4: When output enable is high (`req_oe_low`=0), `sram_we_n` stays low for W = max(cWP, cDW, cEW−S, cAW−S) cycles, which is 2 with the defaults. Here cX is ceil(tX/Tclk).
- R5: When output enable is low (`req_oe_low`=1), `sram_we_n` stays low for max(W, cWZ+cDW) cycles, which is 3 with the defaults.
- R6: With output enable high, `sram_drive` rises together with the fall of `sram_we_n`. With output enable low, it rises cWZ cycles later. It stays high for cDH cycles after the strobe rises. `sram_drive` is never high while the RAM could be driving, that is while `sram_ce_n`=0, `sram_we_n`=1 and `sram_oe_n`=0. `sram_dout` carries the captured data while `sram_drive` is 1.
- R7: While `busy` is sampled 1, `sram_we_n` is not allowed to fall. After the last cycle in which busy was sampled high, the strobe falls no sooner than cBAA+1 edges later.
- R8: `sram_ce_n` and `sram_we_n` rise on the same edge. `ack` is a single-cycle pulse that rises T = max(cDH, cWR, cWC−S−Wmode) cycles after that edge, where T is never negative and is 0 with the defaults.
- R9: `sram_oe_n` equals the inverse of the captured `req_oe_low` from the acceptance edge until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, held until `ack` |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_oe_low | input | 1 | Hold the RAM output enable low during this write |
| busy | input | 1 | Port arbitration busy |
| ack | output | 1 | One-cycle completion pulse |
| sram_addr | output | ADDR_W | RAM address |
| sram_dout | output | DATA_W | Data to the RAM bus |
| sram_drive | output | 1 | Enable for the data bus drivers |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |

## Verification
The bench mixes random writes with both output-enable modes and targets four cases. In the first, the strobe is lengthened with output enable low. A design that ignored the mode would give a 2-cycle pulse with only one cycle of valid data. In the second, the drive enable starts late in the same mode. Starting it at the strobe edge would fight the RAM's still-active outputs. In the third, busy pulses of different lengths, including a single cycle, are applied. An arbiter gate with no settling count, or one counted from the wrong edge, drops the strobe early. In the fourth, the request inputs are scrambled during every cycle and `req` is held high during reset. Missing capture registers would show wrong address or data on the bus, and a missing idle check would start a spurious cycle.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 9,
  parameter int T_AS_NS  = 0,
  parameter int T_WP_NS  = 20,
  parameter int T_EW_NS  = 20,
  parameter int T_AW_NS  = 20,
  parameter int T_DW_NS  = 12,
  parameter int T_WZ_NS  = 10,
  parameter int T_DH_NS  = 0,
  parameter int T_WR_NS  = 0,
  parameter int T_WC_NS  = 25,
  parameter int T_BAA_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_oe_low,
  input  logic              busy,
  output logic              ack,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dout,
  output logic              sram_drive,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  function automatic int cyc(int ns);
    return (ns <= 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CW    = 8;
  localparam int C_DW  = cyc(T_DW_NS);
  localparam int C_WZ  = cyc(T_WZ_NS);
  localparam int C_DH  = cyc(T_DH_NS);
  localparam int C_WC  = cyc(T_WC_NS);
  localparam int C_BAA = cyc(T_BAA_NS);
  localparam int S_LEN = mx(cyc(T_AS_NS), 1);
  localparam int W_HI  = mx(mx(cyc(T_WP_NS), C_DW), mx(cyc(T_EW_NS) - S_LEN, cyc(T_AW_NS) - S_LEN));
  localparam int W_LO  = mx(W_HI, C_WZ + C_DW);
  localparam int TL_HI = mx(mx(C_DH, cyc(T_WR_NS)), C_WC - S_LEN - W_HI);
  localparam int TL_LO = mx(mx(C_DH, cyc(T_WR_NS)), C_WC - S_LEN - W_LO);

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, TAIL} st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, cnt_nxt, baa, w_last, tail_len, d_start;
  logic oe_lat, oe_nxt, accept, gate;

  assign accept   = (st == IDLE) && req && !ack;
  assign gate     = !busy && (baa == '0);
  assign oe_nxt   = accept ? req_oe_low : oe_lat;
  assign w_last   = oe_lat ? CW'(W_LO - 1) : CW'(W_HI - 1);
  assign tail_len = oe_lat ? CW'(TL_LO) : CW'(TL_HI);
  assign d_start  = oe_nxt ? CW'(C_WZ) : '0;

  always_comb begin
    nxt = st;
    case (st)
      IDLE:   if (accept) nxt = SETUP;
      SETUP:  if (cnt >= CW'(S_LEN - 1) && gate) nxt = STROBE;
      STROBE: if (cnt == w_last) nxt = (tail_len == '0) ? IDLE : TAIL;
      TAIL:   if (cnt == tail_len - CW'(1)) nxt = IDLE;
      default: nxt = IDLE;
    endcase
    cnt_nxt = (nxt != st) ? '0 : ((&cnt) ? cnt : cnt + CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      cnt        <= '0;
      baa        <= '0;
      oe_lat     <= 1'b0;
      sram_addr  <= '0;
      sram_dout  <= '0;
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_drive <= 1'b0;
      ack        <= 1'b0;
    end else begin
      st     <= nxt;
      cnt    <= cnt_nxt;
      oe_lat <= oe_nxt;
      baa    <= busy ? CW'(C_BAA) : ((baa != '0) ? baa - CW'(1) : baa);
      if (accept) begin
        sram_addr <= req_addr;
        sram_dout <= req_data;
      end
      sram_ce_n  <= !(nxt == SETUP || nxt == STROBE);
      sram_we_n  <= !(nxt == STROBE);
      sram_oe_n  <= !oe_nxt;
      sram_drive <= (nxt == STROBE && cnt_nxt >= d_start) ||
                    (nxt == TAIL && cnt_nxt < CW'(C_DH));
      ack        <= (nxt == IDLE) && (st != IDLE);
    end
  end

  logic [CW-1:0] wlen;
  always_ff @(posedge clk) begin
    if (rst)             wlen <= '0;
    else if (!sram_we_n) wlen <= wlen + CW'(1);
    else                 wlen <= '0;
  end

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);
  assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> ($past(sram_ce_n) && $past(sram_we_n)));
  assert_min_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (wlen >= CW'(W_HI)));
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    sram_drive |-> (sram_oe_n || !sram_we_n || sram_ce_n));
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> !$past(busy));
  assert_strobes_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> $rose(sram_ce_n));
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 11;
  localparam int DW = 9;

  function automatic int cy(int ns);
    return (ns <= 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int exp_setup();
    return mx(cy(0), 1);
  endfunction
  function automatic int exp_width(bit oe_low);
    int w;
    w = mx(mx(cy(20), cy(12)), mx(cy(20) - exp_setup(), cy(20) - exp_setup()));
    return oe_low ? mx(w, cy(10) + cy(12)) : w;
  endfunction
  function automatic int exp_tail(bit oe_low);
    return mx(0, mx(mx(cy(0), cy(0)), cy(25) - exp_setup() - exp_width(oe_low)));
  endfunction
  function automatic int exp_first_strobe(int b);
    return (b > 0) ? mx(exp_setup(), b + cy(20)) : exp_setup();
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_oe_low = 1'b0;
  logic busy = 1'b0;
  logic ack, sram_drive, sram_ce_n, sram_we_n, sram_oe_n;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dout;

  int checks = 0;
  int errors = 0;

  sram_wr_seq dut_i (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_oe_low(req_oe_low), .busy(busy), .ack(ack), .sram_addr(sram_addr),
    .sram_dout(sram_dout), .sram_drive(sram_drive), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit oe, int b);
    int k = 0, fall = -1, wl = 0, dfirst = -1, dcnt = 0, ackk = -1, celow = 0;
    int bad_addr = 0, bad_data = 0, bad_oe = 0, clash = 0;
    int f, w, ds;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_data = d; req_oe_low = oe; busy = (b > 0);
    while (ackk < 0 && k < 200) begin
      @(negedge clk);
      k++;
      if (!sram_ce_n) celow++;
      if (!sram_we_n) begin
        if (fall < 0) fall = k;
        wl++;
        if (sram_addr !== a) bad_addr++;
        if (sram_oe_n !== !oe) bad_oe++;
      end
      if (sram_drive) begin
        if (dfirst < 0) dfirst = k;
        dcnt++;
        if (sram_dout !== d) bad_data++;
        if (!sram_ce_n && sram_we_n && !sram_oe_n) clash++;
      end
      if (ack) begin
        ackk = k;
        req = 1'b0;
      end
      busy = (k < b);
      req_addr = AW'($urandom);
      req_data = DW'($urandom);
      req_oe_low = 1'($urandom);
    end
    busy = 1'b0;
    f  = exp_first_strobe(b);
    w  = exp_width(oe);
    ds = oe ? cy(10) : 0;
    chk(ackk > 0, "R8 ack arrives", ackk, 1);
    chk(fall == f + 1, oe ? "R3/R7 strobe start oe-low" : "R3/R7 strobe start", fall, f + 1);
    chk(wl == w, oe ? "R5 strobe width oe-low" : "R4 strobe width oe-high", wl, w);
    chk(celow == f + w, "R8 chip enable rises with strobe", celow, f + w);
    chk(dfirst == f + 1 + ds, "R6 drive start", dfirst, f + 1 + ds);
    chk(dcnt == w - ds + cy(0), "R6 drive length", dcnt, w - ds + cy(0));
    chk(clash == 0, "R6 no bus contention", clash, 0);
    chk(bad_addr == 0, "R2 captured address on bus", bad_addr, 0);
    chk(bad_data == 0, "R2 captured data on bus", bad_data, 0);
    chk(bad_oe == 0, "R9 output enable follows mode", bad_oe, 0);
    chk(ackk == f + 1 + w + exp_tail(oe), "R8 ack timing", ackk, f + 1 + w + exp_tail(oe));
    @(negedge clk);
    chk(!ack, "R8 ack single cycle", ack, 0);
    chk(sram_ce_n && sram_oe_n == !oe, "R9 idle hold of oe / R2 no restart", sram_ce_n, 1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    req = 1'b1;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_drive && !ack, "R1 reset state", sram_ce_n, 1);
    req = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_drive && !ack, "R1 after reset", sram_we_n, 1);
    @(negedge clk);
    chk(sram_ce_n, "R1 request during reset not accepted", sram_ce_n, 1);

    do_write(11'h000, 9'h000, 1'b0, 0);
    do_write(11'h7FF, 9'h1FF, 1'b1, 0);
    do_write(11'h155, 9'h0AA, 1'b0, 1);
    do_write(11'h2AA, 9'h155, 1'b1, 4);
    do_write(11'h001, 9'h100, 1'b1, 1);
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = int'($urandom_range(0, 3));
      repeat (gap) @(negedge clk);
      do_write(AW'($urandom), DW'($urandom), 1'($urandom),
               ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 5)) : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule